// File: doc/BRIEF.md
# Serial Zero-Parity and Ones-Modulo-Three Recognizer

This block watches a serial bit stream, one bit per cycle on which the valid strobe is high. It keeps two small residues: the number of zeros seen modulo 2, and the number of ones seen modulo 3. Together they form a six-state machine. A registered flag reports whether the string taken in since the last reset holds an even count of zeros and a count of ones divisible by three.

Synchronous reset starts a new string. The empty string qualifies, so the flag is high straight out of reset. The joint state is brought out on a debug port. The zero-parity bit is the top bit, and the ones residue is the two low bits. Both moduli are parameters. The defaults give the six-state machine described here.

Top module: `zero_one_residue_recognizer`

## Requirements
- R1: While rst is high at a rising edge, the next state is zero parity 0 and ones residue 0, so state_dbg reads 3'b000. accept reads 1 after that edge.
- R2: On an edge where bit_valid is 1 and bit_in is 0, the zero-parity field (state_dbg[2]) toggles. The ones residue (state_dbg[1:0]) is unchanged.
- R3: On an edge where bit_valid is 1 and bit_in is 1, the ones residue steps 0 to 1, 1 to 2 and 2 to 0. The zero-parity field is unchanged.
- R4: On an edge where bit_valid is 0, state_dbg and accept keep their values, whatever bit_in holds.
- R5: After every edge, accept is 1 exactly when state_dbg is 3'b000.
- R6: After each accepted bit, accept equals the test "zeros so far are even and ones so far are a multiple of three", counted over the valid bits since the last reset.
- R7: The ones residue field never shows code 3. A residue register that holds that unused code returns to 0 at the next edge.
- R8: A reset that arrives in the middle of a string takes priority over a valid bit on the same edge. Counting then restarts from the empty string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous, active-high reset; starts a new string |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Consume bit_in on this edge when high |
| accept | output | 1 | Registered flag: the string so far is accepted |
| state_dbg | output | 3 | {zero parity, ones residue[1:0]}, for debug |

## Verification
Every result is due one rising edge after its stimulus. The tracker registers and the accept register load on the same edge that samples bit_valid and bit_in, and no other register lies on the path. The bench changes inputs 2 ns after an edge and reads both outputs 2 ns after the next edge, so each check sees exactly one update. Hold cycles and reset-versus-valid collisions are checked at that same one-cycle offset. This confirms that neither case takes an extra cycle.

// File: rtl/zor_pkg.sv
package zor_pkg;
   // Bit width of a residue register for a given modulus (at least one bit).
   function automatic int residue_width(input int modulus);
      return (modulus <= 2) ? 1 : $clog2(modulus);
   endfunction
endpackage

// File: rtl/zor_residue_tracker.sv
module zor_residue_tracker #(
   parameter  int MOD = 3,
   localparam int W   = zor_pkg::residue_width(MOD)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] q_o,
   output logic [W-1:0] q_next_o
);
   localparam logic [W-1:0] LAST = W'(MOD - 1);

   logic [W-1:0] q;
   logic [W-1:0] nxt;

   generate
      if (MOD < 2) begin : g_bad_mod
         $error("zor_residue_tracker: MOD must be at least 2");
      end

      if ((1 << W) == MOD) begin : g_pow2
         // Every code is legal: natural wrap of the counter.
         always_comb nxt = adv ? q + W'(1) : q;
      end else begin : g_mod
         // Non power of two: explicit wrap and recovery of unused codes.
         always_comb begin
            if (q > LAST)       nxt = '0;
            else if (!adv)      nxt = q;
            else if (q == LAST) nxt = '0;
            else                nxt = q + W'(1);
         end

         assert_range_R7: assert property (@(posedge clk) disable iff (rst)
            int'(q_next_o) < MOD);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
   end

   assign q_o      = q;
   assign q_next_o = nxt;

   assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!adv && int'(q) < MOD) |=> $stable(q_o));
endmodule

// File: rtl/zor_accept_flag.sv
module zor_accept_flag #(
   parameter int ZW = 1,
   parameter int OW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [ZW-1:0] zero_next,
   input  logic [OW-1:0] ones_next,
   output logic          accept_o
);
   logic acc_q;

   // Moore flag registered from the next state, so it lines up with the state.
   always_ff @(posedge clk) begin
      if (rst) acc_q <= 1'b1;
      else     acc_q <= (zero_next == '0) && (ones_next == '0);
   end

   assign accept_o = acc_q;
endmodule

// File: rtl/zero_one_residue_recognizer.sv
module zero_one_residue_recognizer #(
   parameter  int ZERO_MOD = 2,
   parameter  int ONE_MOD  = 3,
   localparam int ZW       = zor_pkg::residue_width(ZERO_MOD),
   localparam int OW       = zor_pkg::residue_width(ONE_MOD)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_in,
   input  logic             bit_valid,
   output logic             accept,
   output logic [ZW+OW-1:0] state_dbg
);
   logic [ZW-1:0] zero_q, zero_n;
   logic [OW-1:0] ones_q, ones_n;
   logic          adv_zero, adv_one;

   generate
      if (ZERO_MOD < 2 || ONE_MOD < 2) begin : g_bad_params
         $error("zero_one_residue_recognizer: moduli must be at least 2");
      end
   endgenerate

   assign adv_zero = bit_valid & ~bit_in;
   assign adv_one  = bit_valid &  bit_in;

   zor_residue_tracker #(.MOD(ZERO_MOD)) u_zero_trk (
      .clk(clk), .rst(rst), .adv(adv_zero), .q_o(zero_q), .q_next_o(zero_n));

   zor_residue_tracker #(.MOD(ONE_MOD)) u_one_trk (
      .clk(clk), .rst(rst), .adv(adv_one), .q_o(ones_q), .q_next_o(ones_n));

   zor_accept_flag #(.ZW(ZW), .OW(OW)) u_accept (
      .clk(clk), .rst(rst), .zero_next(zero_n), .ones_next(ones_n),
      .accept_o(accept));

   assign state_dbg = {zero_q, ones_q};

   assert_zero_step_R2: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && !bit_in) |=>
         (int'(zero_q) == ((int'($past(zero_q)) + 1) % ZERO_MOD)) &&
         (ones_q == $past(ones_q)));

   assert_one_step_R3: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && bit_in) |=>
         (int'(ones_q) == ((int'($past(ones_q)) + 1) % ONE_MOD)) &&
         (zero_q == $past(zero_q)));

   assert_accept_match_R5: assert property (@(posedge clk) disable iff (rst)
      accept == (state_dbg == '0));
endmodule

// File: tb/zero_one_residue_recognizer_bench.sv
`timescale 1ns/1ps
module zero_one_residue_recognizer_bench;
   logic       clk = 1'b0;
   logic       rst;
   logic       bit_in;
   logic       bit_valid;
   logic       accept;
   logic [2:0] state_dbg;

   int checks = 0;
   int errors = 0;
   int zc, oc;

   always #10 clk = ~clk;

   zero_one_residue_recognizer u_zero_one_residue_recognizer (
      .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
      .accept(accept), .state_dbg(state_dbg));

   // {valid, bit, expected state_dbg[2:0], expected accept}, applied after reset
   localparam logic [5:0] VEC [12] = '{
      {2'b11, 3'b001, 1'b0},
      {2'b11, 3'b010, 1'b0},
      {2'b11, 3'b000, 1'b1},
      {2'b10, 3'b100, 1'b0},
      {2'b00, 3'b100, 1'b0},
      {2'b10, 3'b000, 1'b1},
      {2'b10, 3'b100, 1'b0},
      {2'b11, 3'b101, 1'b0},
      {2'b01, 3'b101, 1'b0},
      {2'b11, 3'b110, 1'b0},
      {2'b10, 3'b010, 1'b0},
      {2'b11, 3'b000, 1'b1}
   };

   task automatic check_state(input string req, input logic [2:0] exp);
      checks++;
      if (state_dbg !== exp) begin
         errors++;
         $display("FAIL %s state_dbg actual %b expected %b", req, state_dbg, exp);
      end
   endtask

   task automatic check_acc(input string req, input logic exp);
      checks++;
      if (accept !== exp) begin
         errors++;
         $display("FAIL %s accept actual %b expected %b", req, accept, exp);
      end
   endtask

   // Drive away from the edge, then sample 2 ns after the consuming edge.
   task automatic step(input logic v, input logic b, input logic r);
      bit_valid = v; bit_in = b; rst = r;
      @(posedge clk);
      #2;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit_valid = 1'b0; bit_in = 1'b0; rst = 1'b1;
      @(posedge clk); #2;
      step(1'b1, 1'b1, 1'b1);
      // R1: reset state and empty string accepted
      check_state("R1", 3'b000);
      check_acc("R1", 1'b1);

      // Table walk: R2 zero toggles, R3 ones steps, R4 hold, R5 accept
      foreach (VEC[i]) begin
         step(VEC[i][5], VEC[i][4], 1'b0);
         if (!VEC[i][5])     check_state("R4", VEC[i][3:1]);
         else if (VEC[i][4]) check_state("R3", VEC[i][3:1]);
         else                check_state("R2", VEC[i][3:1]);
         check_acc("R5", VEC[i][0]);
      end

      // R4: many idle cycles with toggling bit_in change nothing
      step(1'b1, 1'b0, 1'b0);   // state 100
      for (int k = 0; k < 6; k++) begin
         step(1'b0, k[0], 1'b0);
         check_state("R4", 3'b100);
         check_acc("R4", 1'b0);
      end

      // R8: reset with a valid bit on the same edge wins
      step(1'b1, 1'b1, 1'b1);
      check_state("R8", 3'b000);
      check_acc("R8", 1'b1);
      step(1'b1, 1'b1, 1'b0);
      check_state("R8", 3'b001);

      // R6 and R7: random stream against software counters
      step(1'b0, 1'b0, 1'b1);
      zc = 0; oc = 0;
      void'($urandom(32'h5eed));
      for (int n = 0; n < 400; n++) begin
         logic v, b;
         v = ($urandom % 4) != 0;
         b = $urandom % 2;
         step(v, b, 1'b0);
         if (v) begin
            if (b) oc++; else zc++;
         end
         check_acc("R6", ((zc % 2) == 0) && ((oc % 3) == 0));
         check_state("R7", {zc[0], 2'(oc % 3)});
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule